// File: doc/BRIEF.md
# Serial Configuration Bitstream Frame Parser

This block takes a device configuration stream one bit at a time. A strobe marks each cycle that carries a bit. The parser first hunts for a header. The header is a run of at least eight 1 bits, then the pattern 0010, then a 24-bit length value. After the header the parser is locked, and it decodes the data frames that follow.

A data frame starts with a 3-bit code, which says whether the frame is full or short. Two parity bits and an 11-bit frame address come next. A full frame then carries an optional run of alignment zeros, a start bit, a fixed-width payload and three stop bits. A short frame goes straight to its stop bits after the address. Each good frame is handed out as a one-cycle pulse with the address, the short-frame flag, the payload and a parity verdict.

The parser counts every bit it receives after the length field. When the count reaches the length value, it raises a done flag and goes back to hunting. Any break in the frame structure raises a sticky format error and also sends the parser back to hunting. The payload width and the number of alignment zeros are parameters. An input selects whether the alignment zeros are present.

Top module: `cfg_frame_parser`

## Requirements
- R1: The parser locks only after at least eight consecutive 1 bits, followed by the bits 0, 0, 1, 0 and then the 24 length bits. A run of seven 1 bits followed by 0010 does not lock it.
- R2: The 24 bits after the 0010 pattern are taken MSB first and shown on `len_count`. When the last of them arrives, `locked` rises and both `fmt_err` and `len_done` clear.
- R3: While the parser waits for a frame code, a leading 1 bit is treated as fill and skipped. The code 010 marks a full frame and 011 marks a short frame, so the third code bit is the short flag. A 0 in the second code position is a format error.
- R4: The code is followed by the odd parity bit, the even parity bit and 11 address bits, MSB first. A frame that ends with good stop bits produces a single-cycle `frm_valid` on the clock edge after its last stop bit. `frm_addr` holds the address during that pulse.
- R5: `frm_par_err` is 1 in the pulse cycle if the odd parity bit does not make the total count of ones (address plus that bit) odd. It is also 1 if the even parity bit does not make that total even. Otherwise it is 0.
- R6: With `par_mode` = 1, a full frame carries ALIGN_ZEROS 0 bits between the address and the start bit. A 1 anywhere in that field is a format error. With `par_mode` = 0, and for short frames in either mode, no alignment bits are expected.
- R7: In a full frame, the start bit after the address (or after the alignment zeros) must be 1. A 0 there is a format error.
- R8: A full frame carries PAYLOAD_W payload bits. The first payload bit received appears at the MSB of `frm_payload`. A short frame shows `frm_comp` = 1 and an all-zero `frm_payload`.
- R9: A 0 in any of the three stop-bit positions is a format error, and no frame pulse is given for that frame.
- R10: After the header, every bit received counts toward the length. On the bit that brings the count to `len_count`, `len_done` rises and `locked` falls.
- R11: Cycles with `bit_valid` = 0 are ignored, whatever value `bit_in` has.
- R12: A format error sets `fmt_err` and drops `locked` on the same edge. `fmt_err` stays set until the next header completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | High when `bit_in` carries a stream bit |
| bit_in | input | 1 | Stream bit |
| par_mode | input | 1 | 1 selects alignment zeros before the start bit of full frames |
| frm_valid | output | 1 | One-cycle pulse for each good frame |
| frm_addr | output | 11 | Frame address |
| frm_comp | output | 1 | 1 for a short (payload-free) frame |
| frm_payload | output | PAYLOAD_W | Frame payload; the first received bit is the MSB |
| frm_par_err | output | 1 | Parity verdict for the frame |
| locked | output | 1 | Header seen, frames being decoded |
| len_count | output | 24 | Captured length value |
| len_done | output | 1 | Length reached (sticky until the next header) |
| fmt_err | output | 1 | Format error (sticky until the next header) |

## Verification
The bench sends a false preamble of seven 1 bits. A design that does not saturate the ones counter correctly would lock on it. It also sends frames in which only the odd parity bit is wrong, and others in which only the even parity bit is wrong. A design that checks just one of the two would pass one of these frames as clean. Alignment zeros are driven in slave-parallel mode, both for a full frame and for a short frame. A parser that inserts the field for short frames, or skips it for full ones, would be misaligned by three bits and would misread the payload. Idle cycles with an inverted data bit are interleaved throughout. The stream length is chosen to end exactly after a few postamble bits, so any error in the bit counter shows up as a late or early `len_done`. Separate error streams break the code, the alignment field, the start bit and a stop bit. Each must raise `fmt_err`, drop the lock and produce no frame.

// File: rtl/cfg_frame_parser.sv
module cfg_frame_parser #(
  parameter int PAYLOAD_W   = 110,
  parameter int ALIGN_ZEROS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_valid,
  input  logic                 bit_in,
  input  logic                 par_mode,
  output logic                 frm_valid,
  output logic [10:0]          frm_addr,
  output logic                 frm_comp,
  output logic [PAYLOAD_W-1:0] frm_payload,
  output logic                 frm_par_err,
  output logic                 locked,
  output logic [23:0]          len_count,
  output logic                 len_done,
  output logic                 fmt_err
);
  localparam int LEN_W  = 24;
  localparam int ADDR_W = 11;
  localparam int MAXC   = (PAYLOAD_W > LEN_W) ? PAYLOAD_W : LEN_W;
  localparam int CNT_W  = $clog2(MAXC + ALIGN_ZEROS + 1);
  localparam bit HAS_ALIGN = ALIGN_ZEROS > 0;
  localparam int ALIGN_LAST = HAS_ALIGN ? ALIGN_ZEROS - 1 : 0;

  typedef enum logic [3:0] {
    S_HUNT, S_SYNC, S_LEN,
    S_CODE0, S_CODE1, S_CODE2, S_OPAR, S_EPAR,
    S_ADDR, S_ALIGN, S_START, S_DATA, S_STOP
  } st_t;

  st_t                  st;
  logic [3:0]           ones;
  logic [CNT_W-1:0]     cnt;
  logic [LEN_W-1:0]     len_q;
  logic [LEN_W-1:0]     tot;
  logic [ADDR_W-1:0]    addr_q;
  logic                 opar_q, epar_q, comp_q;
  logic [PAYLOAD_W-1:0] pay_q;

  wire              in_frames = (st >= S_CODE0);
  wire [LEN_W-1:0]  len_nx    = {len_q[LEN_W-2:0], bit_in};
  wire [LEN_W-1:0]  tot_nx    = tot + 1'b1;
  wire              addr_par  = ^addr_q;

  assign locked      = in_frames;
  assign len_count   = len_q;
  assign frm_addr    = addr_q;
  assign frm_comp    = comp_q;
  assign frm_payload = pay_q;
  assign frm_par_err = (opar_q == addr_par) | (epar_q != addr_par);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_HUNT;
      ones      <= '0;
      cnt       <= '0;
      len_q     <= '0;
      tot       <= '0;
      addr_q    <= '0;
      opar_q    <= 1'b0;
      epar_q    <= 1'b0;
      comp_q    <= 1'b0;
      pay_q     <= '0;
      frm_valid <= 1'b0;
      len_done  <= 1'b0;
      fmt_err   <= 1'b0;
    end else begin
      frm_valid <= 1'b0;
      if (bit_valid) begin
        case (st)
          S_HUNT: begin
            if (bit_in) begin
              if (ones != 4'd8) ones <= ones + 4'd1;
            end else if (ones == 4'd8) begin
              st  <= S_SYNC;
              cnt <= CNT_W'(1);
            end else begin
              ones <= '0;
            end
          end
          S_SYNC: begin
            if (bit_in != (cnt == CNT_W'(2))) begin
              st   <= S_HUNT;
              ones <= bit_in ? 4'd1 : 4'd0;
            end else if (cnt == CNT_W'(3)) begin
              st  <= S_LEN;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_LEN: begin
            len_q <= len_nx;
            cnt   <= cnt + 1'b1;
            if (cnt == CNT_W'(LEN_W - 1)) begin
              fmt_err  <= 1'b0;
              len_done <= (len_nx == '0);
              tot      <= '0;
              ones     <= '0;
              st       <= (len_nx == '0) ? S_HUNT : S_CODE0;
            end
          end
          S_CODE0: if (!bit_in) st <= S_CODE1;
          S_CODE1: begin
            if (bit_in) st <= S_CODE2;
            else begin fmt_err <= 1'b1; st <= S_HUNT; ones <= '0; end
          end
          S_CODE2: begin
            comp_q <= bit_in;
            pay_q  <= '0;
            st     <= S_OPAR;
          end
          S_OPAR: begin opar_q <= bit_in; st <= S_EPAR; end
          S_EPAR: begin epar_q <= bit_in; st <= S_ADDR; cnt <= '0; end
          S_ADDR: begin
            addr_q <= {addr_q[ADDR_W-2:0], bit_in};
            cnt    <= cnt + 1'b1;
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt <= '0;
              if (comp_q)                       st <= S_STOP;
              else if (par_mode && HAS_ALIGN)   st <= S_ALIGN;
              else                              st <= S_START;
            end
          end
          S_ALIGN: begin
            cnt <= cnt + 1'b1;
            if (bit_in) begin fmt_err <= 1'b1; st <= S_HUNT; ones <= '0; end
            else if (cnt == CNT_W'(ALIGN_LAST)) begin st <= S_START; cnt <= '0; end
          end
          S_START: begin
            cnt <= '0;
            if (bit_in) st <= S_DATA;
            else begin fmt_err <= 1'b1; st <= S_HUNT; ones <= '0; end
          end
          S_DATA: begin
            pay_q <= {pay_q[PAYLOAD_W-2:0], bit_in};
            cnt   <= cnt + 1'b1;
            if (cnt == CNT_W'(PAYLOAD_W - 1)) begin st <= S_STOP; cnt <= '0; end
          end
          S_STOP: begin
            cnt <= cnt + 1'b1;
            if (!bit_in) begin fmt_err <= 1'b1; st <= S_HUNT; ones <= '0; end
            else if (cnt == CNT_W'(2)) begin
              frm_valid <= 1'b1;
              st        <= S_CODE0;
              cnt       <= '0;
            end
          end
          default: st <= S_HUNT;
        endcase
        if (in_frames) begin
          tot <= tot_nx;
          if (tot_nx == len_q) begin
            len_done <= 1'b1;
            st       <= S_HUNT;
            ones     <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfg_frame_parser_chk.sv
module cfg_frame_parser_chk #(
  parameter int PW = 110
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_valid,
  input logic          locked,
  input logic          fmt_err,
  input logic          len_done,
  input logic          frm_valid,
  input logic          frm_comp,
  input logic [PW-1:0] frm_payload
);
  a_r2_lock_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (!fmt_err && !len_done));

  a_r12_err_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fmt_err) |-> !locked);

  a_r10_done_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(len_done) |-> !locked);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);

  a_r11_pulse_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> $past(bit_valid));

  a_r8_short_no_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_comp) |-> (frm_payload == '0));
endmodule

bind cfg_frame_parser cfg_frame_parser_chk #(.PW(PAYLOAD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .locked(locked),
  .fmt_err(fmt_err), .len_done(len_done), .frm_valid(frm_valid),
  .frm_comp(frm_comp), .frm_payload(frm_payload)
);

// File: tb/cfg_frame_parser_tb.sv
module cfg_frame_parser_tb;
  localparam int PW = 16;
  localparam int AZ = 3;

  logic clk = 1'b0;
  logic rst_n, bit_valid, bit_in, par_mode;
  logic frm_valid, frm_comp, frm_par_err, locked, len_done, fmt_err;
  logic [10:0] frm_addr;
  logic [PW-1:0] frm_payload;
  logic [23:0] len_count;

  always #4 clk = ~clk;

  cfg_frame_parser #(.PAYLOAD_W(PW), .ALIGN_ZEROS(AZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .par_mode(par_mode), .frm_valid(frm_valid), .frm_addr(frm_addr),
    .frm_comp(frm_comp), .frm_payload(frm_payload), .frm_par_err(frm_par_err),
    .locked(locked), .len_count(len_count), .len_done(len_done), .fmt_err(fmt_err)
  );

  typedef struct packed {
    logic [10:0]   a;
    logic          c;
    logic [PW-1:0] p;
    logic          pe;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit gap = 0;
  int gcnt = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && frm_valid) begin
      if (q.size() == 0) chk(0, "R9 unexpected frame", {21'd0, frm_addr}, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(frm_addr == e.a, "R4 addr", {21'd0, frm_addr}, {21'd0, e.a});
        chk(frm_comp == e.c, "R3 comp flag", {31'd0, frm_comp}, {31'd0, e.c});
        chk(frm_payload == e.p, "R8 payload", {16'd0, frm_payload}, {16'd0, e.p});
        chk(frm_par_err == e.pe, "R5 parity", {31'd0, frm_par_err}, {31'd0, e.pe});
      end
    end
  end

  task automatic send_bit(input logic b);
    bit_in = b;
    bit_valid = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    gcnt++;
    if (gap && (gcnt % 3 == 0)) begin
      bit_in = ~b;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic send_header(input logic [23:0] len, input int nones);
    repeat (nones) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    for (int i = 23; i >= 0; i--) send_bit(len[i]);
  endtask

  task automatic send_head(input logic [10:0] a, input logic c, input bit bo, input bit be);
    logic ap;
    ap = ^a;
    send_bit(1'b0); send_bit(1'b1); send_bit(c);
    send_bit(~ap ^ bo);
    send_bit(ap ^ be);
    for (int i = 10; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic send_frame(input logic [10:0] a, input logic c, input logic [PW-1:0] p,
                            input bit bo, input bit be, input bit pm);
    exp_t e;
    e.a = a; e.c = c; e.p = c ? '0 : p; e.pe = bo | be;
    q.push_back(e);
    send_head(a, c, bo, be);
    if (!c) begin
      if (pm) repeat (AZ) send_bit(1'b0);
      send_bit(1'b1);
      for (int i = PW - 1; i >= 0; i--) send_bit(p[i]);
    end
    repeat (3) send_bit(1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int len;
    bit_in = 0; bit_valid = 0; par_mode = 0; rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!frm_valid, "R4 reset frm_valid", {31'd0, frm_valid}, 0);
    chk(!locked, "R1 reset locked", {31'd0, locked}, 0);
    chk(!fmt_err, "R12 reset fmt_err", {31'd0, fmt_err}, 0);
    chk(!len_done, "R10 reset len_done", {31'd0, len_done}, 0);

    // serial mode, gaps with flipped data (R11)
    gap = 1;
    len = 36 + 19 + 36 + 36 + 5;
    send_header(24'(len), 10);
    chk(locked, "R2 locked after header", {31'd0, locked}, 1);
    chk(len_count == 24'(len), "R2 len_count", {8'd0, len_count}, len);
    send_frame(11'h5A3, 1'b0, 16'hBEEF, 0, 0, 0);
    send_frame(11'h001, 1'b1, 16'h1234, 0, 0, 0);
    send_frame(11'h7FF, 1'b0, 16'h8001, 1, 0, 0);
    send_frame(11'h2C4, 1'b0, 16'h0F0F, 0, 1, 0);
    repeat (4) send_bit(1'b1);
    chk(!len_done, "R10 not done early", {31'd0, len_done}, 0);
    send_bit(1'b1);
    chk(len_done, "R10 len_done", {31'd0, len_done}, 1);
    chk(!locked, "R10 lock dropped", {31'd0, locked}, 0);
    chk(!fmt_err, "R11 no error with gaps", {31'd0, fmt_err}, 0);
    chk(q.size() == 0, "R4 all frames seen", q.size(), 0);

    // slave-parallel alignment (R6)
    gap = 0;
    par_mode = 1;
    len = 39 + 19 + 3;
    send_header(24'(len), 8);
    send_frame(11'h155, 1'b0, 16'hA5C3, 0, 0, 1);
    send_frame(11'h6AA, 1'b1, 16'hFFFF, 0, 0, 1);
    repeat (3) send_bit(1'b1);
    chk(q.size() == 0, "R6 aligned frames seen", q.size(), 0);
    chk(len_done && !fmt_err, "R6 clean end", {30'd0, len_done, fmt_err}, 2);

    // short preamble must not lock (R1)
    repeat (7) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    for (int i = 0; i < 24; i++) send_bit(i[0]);
    chk(!locked, "R1 seven ones no lock", {31'd0, locked}, 0);

    // bad code (R3)
    par_mode = 0;
    send_header(24'd200, 9);
    chk(locked && !fmt_err, "R2 relock", {30'd0, locked, fmt_err}, 2);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    chk(fmt_err, "R3 bad code", {31'd0, fmt_err}, 1);
    chk(!locked, "R12 lock dropped on error", {31'd0, locked}, 0);

    // nonzero alignment bit (R6)
    send_header(24'd200, 8);
    chk(!fmt_err, "R12 error cleared by header", {31'd0, fmt_err}, 0);
    par_mode = 1;
    send_head(11'h123, 1'b0, 0, 0);
    send_bit(1'b0);
    chk(!fmt_err, "R6 zero accepted", {31'd0, fmt_err}, 0);
    send_bit(1'b1);
    chk(fmt_err, "R6 alignment one", {31'd0, fmt_err}, 1);

    // missing start bit (R7)
    par_mode = 0;
    send_header(24'd200, 8);
    send_head(11'h0F0, 1'b0, 0, 0);
    send_bit(1'b0);
    chk(fmt_err, "R7 missing start", {31'd0, fmt_err}, 1);

    // zero stop bit (R9)
    send_header(24'd200, 8);
    send_head(11'h321, 1'b1, 0, 0);
    send_bit(1'b1); send_bit(1'b0);
    chk(fmt_err, "R9 zero stop", {31'd0, fmt_err}, 1);
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R9 no frame out", q.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule